// File: doc/BRIEF.md
# Compare-Match Timer/Counter

This block is a bus-mapped timer that counts prescaled clock ticks in an up-counter of selectable width (8, 16 or 32 bits). Two compare channels watch the count and raise match flags. The counter either runs through its full range and wraps to zero after the all-ones value, or it treats compare channel 0 as its top value and wraps to zero after reaching it. Channel 1 only compares in either case.

Software drives the block through seven word registers on a simple read/write strobe bus. Each write and each read is accepted in one cycle, and read data is registered. The interrupt mask has separate set and clear registers. The flags are cleared by writing ones. A single level interrupt line is high while any flag is set and that flag's mask bit is also set. A self-clearing reset bit returns the whole register file to its defaults.

Top module: `cmtc_timer`

Register words, by address: 0 control, 1 mask-clear, 2 mask-set, 3 flags, 4 count, 5 compare 0, 6 compare 1. Addresses 5 and 6 hold the channel 0 and channel 1 compare values. Control fields: bit 0 run, bit 1 soft reset, bits 3:2 width code, bit 4 top select (0 = wrap at all-ones, 1 = wrap at compare 0), bits 7:5 prescaler code. Flag and mask bit i belong to channel i.

## Requirements
- R1: After the reset input, every register reads 0 and the interrupt line is low.
- R2: Prescaler codes 0 to 4 advance the count once every 1, 2, 4, 8 or 16 clocks. Codes 5, 6 and 7 advance it once every 64, 256 or 1024 clocks. The first advance comes one full period after run is set.
- R3: With top select 0, the count wraps from the all-ones value of the selected width to 0.
- R4: With top select 1, the count wraps to 0 on the tick where it equals compare 0. Compare 1 never resets the count.
- R5: Width code 01 gives 8 bits, 10 gives 32 bits, and 00 or 11 gives 16 bits. Count and compare registers read back masked to that width, and the compares use that width.
- R6: On a tick where the masked count equals the masked compare value of channel i, flag i is set at that clock edge.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. If a match arrives in the same cycle as the clear, the flag stays set.
- R8: Writing ones to the mask-set register sets those mask bits. Writing ones to the mask-clear register clears them. Reading either register returns the mask.
- R9: The interrupt line equals the OR over channels of (flag AND mask bit), and it changes at the same edge as the flags and the mask.
- R10: Writing 1 to the soft reset bit makes control read with bit 1 set during the next cycle. At the edge after that, all registers return to 0 and the bit clears itself. Bus writes during that cycle are ignored.
- R11: With run at 0, the count holds its value. The prescaler restarts on every enable.
- R12: A write to the count register loads the written value, masked to the width, and takes priority over a tick in the same cycle.
- R13: Read data appears on the cycle after the read strobe. Addresses 7 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Most internal faults only appear as a count, flag or interrupt at the ports. A wrong prescaler period or wrong wrap point shows up as a count read that is off. Depending on the prescaler code, that happens within one tick period, from 1 up to 1024 clocks. A wrong flag or mask state shows up on the interrupt line at the very next edge, because the line is compared against an independent model every cycle. A faulty soft reset or a faulty clear-versus-match priority shows up on the first read that follows it.

// File: rtl/cmtc_pkg.sv
package cmtc_pkg;
  localparam int BUS_W = 32;
  localparam int NCH   = 2;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MSKCLR = 3'd1,
    A_MSKSET = 3'd2,
    A_FLAGS  = 3'd3,
    A_COUNT  = 3'd4,
    A_CMP0   = 3'd5,
    A_CMP1   = 3'd6
  } reg_addr_e;

  localparam int B_RUN  = 0;
  localparam int B_SRST = 1;
  localparam int B_WID  = 2;
  localparam int B_TOP  = 4;
  localparam int B_PSC  = 5;

  function automatic logic [BUS_W-1:0] width_mask(input logic [1:0] code);
    case (code)
      2'b01:   width_mask = 32'h0000_00FF;
      2'b10:   width_mask = 32'hFFFF_FFFF;
      default: width_mask = 32'h0000_FFFF;
    endcase
  endfunction

  function automatic int unsigned div_of(input logic [2:0] code);
    if (code <= 3'd4) div_of = 32'd1 << code;
    else              div_of = 32'd1 << (2 * int'(code) - 4);
  endfunction
endpackage

// File: rtl/cmtc_prescale.sv
module cmtc_prescale #(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  import cmtc_pkg::*;

  logic [PSC_W-1:0] pre_q;
  logic [PSC_W-1:0] last;

  assign last = PSC_W'(div_of(code) - 1);
  assign tick = run && (pre_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cmtc_counter.sv
module cmtc_counter
  import cmtc_pkg::*;
#(
  parameter int CW = BUS_W,
  parameter int NC = NCH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 tick,
  input  logic                 top_cmp,
  input  logic [CW-1:0]        mask,
  input  logic [NC-1:0][CW-1:0] cmp,
  input  logic                 ld,
  input  logic [CW-1:0]        ld_val,
  output logic [CW-1:0]        cnt_q,
  output logic [NC-1:0]        match
);
  logic [CW-1:0] cnt_m;
  logic          wrap;

  assign cnt_m = cnt_q & mask;

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    assign match[i] = tick && (cnt_m == (cmp[i] & mask));
  end

  assign wrap = (top_cmp && match[0]) || (cnt_m == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (ld)     cnt_q <= ld_val & mask;
    else if (tick)   cnt_q <= wrap ? '0 : cnt_m + 1'b1;
  end
endmodule

// File: rtl/cmtc_irq.sv
module cmtc_irq #(
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [NC-1:0] match,
  input  logic          flag_wr,
  input  logic          set_wr,
  input  logic          unset_wr,
  input  logic [NC-1:0] wbits,
  output logic [NC-1:0] flag_q,
  output logic [NC-1:0] msk_q,
  output logic          irq_q
);
  logic [NC-1:0] flag_d;
  logic [NC-1:0] msk_d;

  always_comb begin
    flag_d = match | (flag_q & ~(flag_wr ? wbits : '0));
    msk_d  = msk_q;
    if (set_wr)   msk_d = msk_d | wbits;
    if (unset_wr) msk_d = msk_d & ~wbits;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag_q <= '0;
      msk_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      msk_q  <= msk_d;
      irq_q  <= |(flag_d & msk_d);
    end
  end
endmodule

// File: rtl/cmtc_timer.sv
module cmtc_timer
  import cmtc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PSC_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic                     en_q, srst_q, top_q;
  logic [1:0]               wid_q;
  logic [2:0]               psc_q;
  logic [NCH-1:0][BUS_W-1:0] cmp_q;
  logic [BUS_W-1:0]         cnt_q, mask;
  logic [NCH-1:0]           match, flag_q, msk_q;
  logic                     tick, run, wr_ok;
  logic                     ctrl_wr, cnt_wr, flag_wr, set_wr, unset_wr;

  assign wr_ok    = bus_wr && !srst_q;
  assign ctrl_wr  = wr_ok && (bus_addr == ADDR_W'(A_CTRL));
  assign unset_wr = wr_ok && (bus_addr == ADDR_W'(A_MSKCLR));
  assign set_wr   = wr_ok && (bus_addr == ADDR_W'(A_MSKSET));
  assign flag_wr  = wr_ok && (bus_addr == ADDR_W'(A_FLAGS));
  assign cnt_wr   = wr_ok && (bus_addr == ADDR_W'(A_COUNT));
  assign run      = en_q && !srst_q;
  assign mask     = width_mask(wid_q);

  always_ff @(posedge clk) begin
    if (rst || srst_q) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      top_q  <= 1'b0;
      wid_q  <= 2'b00;
      psc_q  <= 3'd0;
    end else if (ctrl_wr) begin
      en_q   <= bus_wdata[B_RUN];
      srst_q <= bus_wdata[B_SRST];
      wid_q  <= bus_wdata[B_WID +: 2];
      top_q  <= bus_wdata[B_TOP];
      psc_q  <= bus_wdata[B_PSC +: 3];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmpreg
    always_ff @(posedge clk) begin
      if (rst || srst_q)
        cmp_q[i] <= '0;
      else if (wr_ok && (bus_addr == ADDR_W'(int'(A_CMP0) + i)))
        cmp_q[i] <= bus_wdata;
    end
  end

  cmtc_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .code (psc_q),
    .tick (tick)
  );

  cmtc_counter #(.CW(BUS_W), .NC(NCH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (srst_q),
    .tick    (tick),
    .top_cmp (top_q),
    .mask    (mask),
    .cmp     (cmp_q),
    .ld      (cnt_wr),
    .ld_val  (bus_wdata),
    .cnt_q   (cnt_q),
    .match   (match)
  );

  cmtc_irq #(.NC(NCH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .clr      (srst_q),
    .match    (match),
    .flag_wr  (flag_wr),
    .set_wr   (set_wr),
    .unset_wr (unset_wr),
    .wbits    (bus_wdata[NCH-1:0]),
    .flag_q   (flag_q),
    .msk_q    (msk_q),
    .irq_q    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CTRL):   bus_rdata <= BUS_W'({psc_q, top_q, wid_q, srst_q, en_q});
        ADDR_W'(A_MSKCLR),
        ADDR_W'(A_MSKSET): bus_rdata <= BUS_W'(msk_q);
        ADDR_W'(A_FLAGS):  bus_rdata <= BUS_W'(flag_q);
        ADDR_W'(A_COUNT):  bus_rdata <= cnt_q & mask;
        ADDR_W'(A_CMP0):   bus_rdata <= cmp_q[0] & mask;
        ADDR_W'(A_CMP1):   bus_rdata <= cmp_q[1] & mask;
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmtc_checker.sv
module cmtc_checker (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        srst,
  input logic        tick,
  input logic        top,
  input logic [1:0]  match,
  input logic [31:0] cnt,
  input logic [31:0] mask,
  input logic [1:0]  flags,
  input logic [1:0]  msk,
  input logic        irq,
  input logic        flag_wr,
  input logic        wbit0,
  input logic        cnt_wr
);
  // R3: wrap at all-ones in full-range mode
  a_r3_wrap_at_max: assert property (@(posedge clk) disable iff (rst)
    (tick && !top && !match[0] && ((cnt & mask) == mask) && !cnt_wr) |=> (cnt == 32'd0));

  // R4: wrap at compare 0 in top-select mode
  a_r4_wrap_at_cmp0: assert property (@(posedge clk) disable iff (rst)
    (tick && top && match[0] && !cnt_wr) |=> (cnt == 32'd0));

  // R6: a match always leaves its flag set
  a_r6_flag_after_match: assert property (@(posedge clk) disable iff (rst)
    match[0] |=> flags[0]);

  // R7: write-one clears when no match competes
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wbit0 && !match[0]) |=> !flags[0]);

  // R9: interrupt line tracks flags and mask
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & msk));

  // R10: soft reset returns state to defaults
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!en && !srst && flags == 2'b00 && msk == 2'b00 && cnt == 32'd0 && !irq));

  // R11: stopped counter holds
  a_r11_freeze: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr && !srst) |=> $stable(cnt));
endmodule

bind cmtc_timer cmtc_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en_q),
  .srst    (srst_q),
  .tick    (tick),
  .top     (top_q),
  .match   (match),
  .cnt     (cnt_q),
  .mask    (mask),
  .flags   (flag_q),
  .msk     (msk_q),
  .irq     (irq_o),
  .flag_wr (flag_wr),
  .wbit0   (bus_wdata[0]),
  .cnt_wr  (cnt_wr)
);

// File: tb/cmtc_timer_tb.sv
module cmtc_timer_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int vectors = 0, misses = 0;
  bit done = 0;

  // reference state, derived from the requirements
  bit m_en, m_srst, m_top, m_irq;
  bit [1:0] m_wid, m_flag, m_msk;
  bit [2:0] m_psc;
  bit [31:0] m_cnt, m_cmp0, m_cmp1;
  int unsigned m_pre;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmtc_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic bit [31:0] f_mask(bit [1:0] c);
    return (c == 2'b01) ? 32'hFF : (c == 2'b10) ? 32'hFFFF_FFFF : 32'hFFFF;
  endfunction

  function automatic int unsigned f_period(bit [2:0] c);
    int unsigned tbl[8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
    return tbl[c];
  endfunction

  function automatic bit [31:0] f_read(bit [2:0] a);
    case (a)
      3'd0: return {24'd0, m_psc, m_top, m_wid, m_srst, m_en};
      3'd1, 3'd2: return {30'd0, m_msk};
      3'd3: return {30'd0, m_flag};
      3'd4: return m_cnt & f_mask(m_wid);
      3'd5: return m_cmp0 & f_mask(m_wid);
      3'd6: return m_cmp1 & f_mask(m_wid);
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input bit w, input bit r, input bit [2:0] a, input bit [31:0] d,
                      input string tag);
    bit [31:0] exp_rd, mk, cm, n_cnt;
    bit tk, run, mt0, mt1;
    bit [1:0] n_flag, n_msk;
    int unsigned n_pre;
    exp_rd = f_read(a);
    mk  = f_mask(m_wid);
    run = m_en && !m_srst;
    tk  = run && (m_pre >= f_period(m_psc) - 1);
    n_pre = (!run || tk) ? 0 : m_pre + 1;
    cm  = m_cnt & mk;
    mt0 = tk && (cm == (m_cmp0 & mk));
    mt1 = tk && (cm == (m_cmp1 & mk));
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (m_srst) begin
      {m_en, m_srst, m_top, m_wid, m_psc} = '0;
      m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0; m_flag = 0; m_msk = 0; m_irq = 0;
      m_pre = 0;
    end else begin
      n_cnt = tk ? (((m_top && mt0) || cm == mk) ? 32'd0 : cm + 1) : m_cnt;
      n_flag = {mt1, mt0} | (m_flag & ~((w && a == 3'd3) ? d[1:0] : 2'b00));
      n_msk = m_msk;
      if (w && a == 3'd2) n_msk = n_msk | d[1:0];
      if (w && a == 3'd1) n_msk = n_msk & ~d[1:0];
      if (w && a == 3'd4) n_cnt = d & mk;
      if (w && a == 3'd5) m_cmp0 = d;
      if (w && a == 3'd6) m_cmp1 = d;
      if (w && a == 3'd0) begin
        m_en = d[0]; m_srst = d[1]; m_wid = d[3:2]; m_top = d[4]; m_psc = d[7:5];
      end
      m_cnt = n_cnt; m_flag = n_flag; m_msk = n_msk; m_pre = n_pre;
      m_irq = |(n_flag & n_msk);
    end
    vectors++;
    if (irq_o !== m_irq) begin
      misses++;
      $display("FAIL R9 (%s) irq actual=%0b expected=%0b", tag, irq_o, m_irq);
    end
    if (r) begin
      vectors++;
      if (bus_rdata !== exp_rd) begin
        misses++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tag, a, bus_rdata, exp_rd);
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: every register and the interrupt line come out of reset at zero
    for (int a = 0; a < 8; a++) begin
      step(0, 1, 3'(a), 0, "R1");
      vectors++;
      if (bus_rdata !== 32'd0 || irq_o !== 1'b0) begin
        misses++;
        $display("FAIL R1 addr=%0d actual=%h expected=0", a, bus_rdata);
      end
    end
    // R13: unmapped read
    step(0, 1, 3'd7, 0, "R13");
    // R3, R5: 8-bit wrap at 255
    step(1, 0, 3'd4, 32'h1FA, "R12");
    step(1, 0, 3'd0, 32'h05, "R3");
    idle(8, "R3");
    step(0, 1, 3'd4, 0, "R3");
    step(0, 1, 3'd5, 0, "R5");
    // R11: stop and hold
    step(1, 0, 3'd0, 32'h04, "R11");
    idle(5, "R11");
    step(0, 1, 3'd4, 0, "R11");
    // R4: top = compare 0 in 16-bit, compare 1 does not reset
    step(1, 0, 3'd5, 32'd5, "R4");
    step(1, 0, 3'd6, 32'd3, "R4");
    step(1, 0, 3'd4, 32'd0, "R12");
    step(1, 0, 3'd2, 32'd3, "R8");
    step(0, 1, 3'd1, 0, "R8");
    step(1, 0, 3'd0, 32'h11, "R4");
    for (int i = 0; i < 14; i++) step(0, 1, 3'd4, 0, "R4");
    step(0, 1, 3'd3, 0, "R6");
    step(1, 0, 3'd1, 32'd1, "R8");
    step(0, 1, 3'd2, 0, "R8");
    // R7: clear colliding with a match keeps the flag
    step(1, 0, 3'd0, 32'h10, "R7");
    step(1, 0, 3'd4, 32'd0, "R7");
    step(1, 0, 3'd5, 32'd3, "R7");
    step(1, 0, 3'd3, 32'd3, "R7");
    step(1, 0, 3'd0, 32'h11, "R7");
    idle(3, "R7");
    step(1, 0, 3'd3, 32'd1, "R7");
    step(0, 1, 3'd3, 0, "R7");
    step(1, 0, 3'd3, 32'd0, "R7");
    step(0, 1, 3'd3, 0, "R7");
    // R2: prescaler code 5 (64 clocks per tick) in 32-bit width
    step(1, 0, 3'd0, 32'h08, "R2");
    step(1, 0, 3'd4, 32'd0, "R2");
    step(1, 0, 3'd0, 32'hA9, "R2");
    for (int i = 0; i < 4; i++) begin
      idle(40, "R2");
      step(0, 1, 3'd4, 0, "R2");
    end
    // R10: soft reset
    step(1, 0, 3'd0, 32'h03, "R10");
    step(0, 1, 3'd0, 0, "R10");
    step(0, 1, 3'd0, 0, "R10");
    step(0, 1, 3'd5, 0, "R10");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int unsigned r = $urandom % 20;
      bit [31:0] d = $urandom;
      if (r < 2) begin
        d[1] = (($urandom % 8) == 0);
        d[0] = (($urandom % 4) != 0);
        if (($urandom % 3) != 0) d[7:5] = 3'($urandom % 3);
        step(1, 0, 3'd0, d, "R5");
      end else if (r < 4) step(1, 0, 3'(5 + ($urandom % 2)), d & 32'h1F, "R6");
      else if (r < 5) step(1, 0, 3'd4, d, "R12");
      else if (r < 7) step(1, 0, 3'(1 + ($urandom % 2)), d, "R8");
      else if (r < 9) step(1, 0, 3'd3, d, "R7");
      else if (r < 15) step(0, 1, 3'($urandom % 8), 0, "R13");
      else step(0, 0, 3'd0, 0, "R2");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule